// File: doc/BRIEF.md
# Two-Stage Conversion Result Buffer

This block sits between a multichannel converter and the serial path that a host uses to fetch results. Every channel keeps two one-result registers. The newest register takes each fresh sample. The host-facing register holds the value that the serial shifter sends out. The host-facing register lags the newest sample by at most one result. If the host falls two results behind, both registers jump to the latest sample and an overflow pulse reports that data was discarded.

The channels share one new-data strobe and one read-complete strobe, so a single control unit serves all of them. The serial shifter raises the read-complete strobe when it has finished shifting out a frame. The unread flag tells the host whether the host-facing registers hold a sample that has not yet been read. When a read-complete and a new-data strobe come in the same cycle, the read is handled first and the new data second.

Top module: `conv_result_buf`

## Requirements
- R1: After reset, every `holdData` lane is 0, and `unread` and `overflow` are 0.
- R2: The newest register of each channel loads `chanData` on every cycle where `newData` is 1, whatever the flag state. This is seen at the ports when a later read copies that value into `holdData`.
- R3: When `newData` arrives and the host has already read the held sample, `holdData` takes the new sample and `unread` becomes 1.
- R4: When `newData` arrives while the held sample is unread and no newer sample is pending, `holdData` keeps its value and `unread` stays 1.
- R5: A read-complete while a newer sample is pending copies that newer sample into `holdData`, and `unread` stays 1.
- R6: When `newData` arrives while the held sample is unread and a newer sample is already pending, `holdData` takes the new sample, and `overflow` is 1 for exactly the following cycle.
- R7: A read-complete with no pending sample clears `unread` and leaves `holdData` unchanged. Repeated reads return the same value until new data arrives.
- R8: When `readDone` and `newData` are both 1 in one cycle, the read is processed first and the new data second.
- R9: `overflow` is 0 in every cycle that does not follow a discard. All outputs change only on the clock edge that takes the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| newData | input | 1 | Common strobe: a new sample is present on `chanData` |
| chanData | input | NUM_CH*RES_W | Per-channel samples; channel c is in bits [c*RES_W +: RES_W] |
| readDone | input | 1 | Strobe from the serial path: the host finished reading the held samples |
| holdData | output | NUM_CH*RES_W | Host-facing register of each channel, packed in the same layout as `chanData` |
| unread | output | 1 | The host-facing samples have not been read since they were loaded |
| overflow | output | 1 | One-cycle pulse: unread samples were discarded |

## Verification
The bench builds the block with the default three channels of 24 bits. Because both strobes are common to all channels, the whole control state is two flags. The bench drives every sequence of four cycles over the four combinations of the two strobes, each sequence starting from reset. This reaches every pairing of flag state and strobe combination, including the case where a read and new data come in the same cycle and the case of a second missed sample. Each sample value is unique per sequence, step and channel. A wrong copy source or a lost update therefore shows up as a value mismatch against the bench's own model of the requirements.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

  // Strobes from the control unit to every channel lane
  typedef struct packed {
    logic loadOut;      // newest register takes the incoming sample
    logic holdFromIn;   // host-facing register takes the incoming sample
    logic holdFromOut;  // host-facing register copies the newest register
  } bufCtrl_t;

endpackage

// File: rtl/cbuf_ctrl.sv
module cbuf_ctrl
  import cbuf_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     newData,
  input  logic     readDone,
  output bufCtrl_t ctrl,
  output logic     unread,
  output logic     pending,
  output logic     overflow
);

  logic unreadQ, pendingQ, overflowQ;
  logic unreadMid, pendingMid;
  logic unreadNxt, pendingNxt, overflowNxt;

  // The read is applied first, then the new data on top of it
  always_comb begin
    unreadMid  = readDone ? pendingQ : unreadQ;
    pendingMid = readDone ? 1'b0 : pendingQ;

    ctrl.loadOut     = newData;
    ctrl.holdFromOut = readDone && pendingQ;
    ctrl.holdFromIn  = newData && (!unreadMid || pendingMid);

    unreadNxt   = newData ? 1'b1 : unreadMid;
    pendingNxt  = newData ? (unreadMid && !pendingMid) : pendingMid;
    overflowNxt = newData && unreadMid && pendingMid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unreadQ   <= 1'b0;
      pendingQ  <= 1'b0;
      overflowQ <= 1'b0;
    end else begin
      unreadQ   <= unreadNxt;
      pendingQ  <= pendingNxt;
      overflowQ <= overflowNxt;
    end
  end

  assign unread   = unreadQ;
  assign pending  = pendingQ;
  assign overflow = overflowQ;

  AST_PEND_NEEDS_UNREAD: assert property (@(posedge clk) disable iff (!rstN)
    pendingQ |-> unreadQ); // R9
  AST_NEW_SETS_UNREAD: assert property (@(posedge clk) disable iff (!rstN)
    newData |=> unreadQ); // R3
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    overflowQ |=> !overflowQ); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (readDone && !pendingQ && !newData) |=> !unreadQ); // R7

endmodule

// File: rtl/cbuf_lane.sv
module cbuf_lane
  import cbuf_pkg::*;
#(
  parameter int RES_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  bufCtrl_t         ctrl,
  input  logic [RES_W-1:0] din,
  output logic [RES_W-1:0] holdQ,
  output logic [RES_W-1:0] outQ
);

  logic [RES_W-1:0] outReg, holdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg  <= '0;
      holdReg <= '0;
    end else begin
      if (ctrl.loadOut) outReg <= din;
      if (ctrl.holdFromIn)       holdReg <= din;
      else if (ctrl.holdFromOut) holdReg <= outReg;
    end
  end

  assign holdQ = holdReg;
  assign outQ  = outReg;

  AST_OUT_TAKES_NEW: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadOut |=> outReg == $past(din)); // R2

endmodule

// File: rtl/conv_result_buf.sv
module conv_result_buf
  import cbuf_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int RES_W  = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    newData,
  input  logic [NUM_CH*RES_W-1:0] chanData,
  input  logic                    readDone,
  output logic [NUM_CH*RES_W-1:0] holdData,
  output logic                    unread,
  output logic                    overflow
);

  localparam int BUS_W = NUM_CH * RES_W;

  bufCtrl_t         ctrl;
  logic             pending;
  logic [BUS_W-1:0] outData;

  cbuf_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .newData  (newData),
    .readDone (readDone),
    .ctrl     (ctrl),
    .unread   (unread),
    .pending  (pending),
    .overflow (overflow)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    cbuf_lane #(.RES_W(RES_W)) lane_i (
      .clk   (clk),
      .rstN  (rstN),
      .ctrl  (ctrl),
      .din   (chanData[c*RES_W +: RES_W]),
      .holdQ (holdData[c*RES_W +: RES_W]),
      .outQ  (outData[c*RES_W +: RES_W])
    );

    AST_NO_LAG_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      !pending |-> holdData[c*RES_W +: RES_W] == outData[c*RES_W +: RES_W]); // R4
  end

endmodule

// File: tb/conv_result_buf_tb_top.sv
module conv_result_buf_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 3;
  localparam int RES_W  = 24;
  localparam int STEPS  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic newData = 1'b0;
  logic readDone = 1'b0;
  logic [NUM_CH*RES_W-1:0] chanData = '0;
  logic [NUM_CH*RES_W-1:0] holdData;
  logic unread, overflow;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [RES_W-1:0] mOut [NUM_CH];
  logic [RES_W-1:0] mHold [NUM_CH];
  logic mU, mP, mOvf;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_result_buf #(.NUM_CH(NUM_CH), .RES_W(RES_W)) dut_i (
    .clk(clk), .rstN(rstN), .newData(newData), .chanData(chanData),
    .readDone(readDone), .holdData(holdData), .unread(unread), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [RES_W-1:0] act, input logic [RES_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input string ovfTag);
    for (int c = 0; c < NUM_CH; c++)
      chk({tag, " hold"}, holdData[c*RES_W +: RES_W], mHold[c]);
    chk({tag, " unread"}, {23'd0, unread}, {23'd0, mU});
    chk({ovfTag, " overflow"}, {23'd0, overflow}, {23'd0, mOvf});
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; newData = 1'b0; readDone = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    for (int c = 0; c < NUM_CH; c++) begin mOut[c] = '0; mHold[c] = '0; end
    mU = 1'b0; mP = 1'b0; mOvf = 1'b0;
    checkAll("R1", "R1");
  endtask

  // one cycle with the given strobes; we are just after a falling edge
  task automatic doStep(input logic nd, input logic rd, input int seqId, input int stepId);
    logic [RES_W-1:0] din [NUM_CH];
    logic u1, p1;
    string tag;
    for (int c = 0; c < NUM_CH; c++) begin
      din[c] = RES_W'((seqId << 8) | (stepId << 4) | (c + 1)) ^ 24'hA50000;
      chanData[c*RES_W +: RES_W] = din[c];
    end
    newData = nd; readDone = rd;
    if (rd && nd)       tag = "R8";
    else if (rd && mP)  tag = "R5 R2";
    else if (rd)        tag = "R7";
    else if (nd && !mU) tag = "R3";
    else if (nd && !mP) tag = "R4";
    else if (nd)        tag = "R6";
    else                tag = "R7";
    u1 = mU; p1 = mP;
    if (rd) begin
      if (mP) begin
        for (int c = 0; c < NUM_CH; c++) mHold[c] = mOut[c];
        u1 = 1'b1; p1 = 1'b0;
      end else u1 = 1'b0;
    end
    mOvf = 1'b0;
    if (nd) begin
      if (!u1) begin
        for (int c = 0; c < NUM_CH; c++) begin mHold[c] = din[c]; mOut[c] = din[c]; end
        u1 = 1'b1;
      end else if (!p1) begin
        for (int c = 0; c < NUM_CH; c++) mOut[c] = din[c];
        p1 = 1'b1;
      end else begin
        for (int c = 0; c < NUM_CH; c++) begin mHold[c] = din[c]; mOut[c] = din[c]; end
        p1 = 1'b0; mOvf = 1'b1;
      end
    end
    mU = u1; mP = p1;
    @(negedge clk);
    newData = 1'b0; readDone = 1'b0;
    checkAll(tag, mOvf ? "R6" : "R9");
  endtask

  initial begin
    // exhaustive: every 4-cycle sequence of the four strobe combinations
    for (int s = 0; s < (1 << (2*STEPS)); s++) begin
      doReset();
      for (int k = 0; k < STEPS; k++)
        doStep(s[2*k], s[2*k+1], s, k);
      // idle cycle: nothing may change
      doStep(1'b0, 1'b0, s, STEPS);
    end
    // directed: repeated reads of one sample return it unchanged
    doReset();
    doStep(1'b1, 1'b0, 300, 0);
    for (int k = 1; k < 5; k++) doStep(1'b0, 1'b1, 300, k);
    // directed: host never reads, overflow on every second sample
    doReset();
    for (int k = 0; k < 8; k++) doStep(1'b1, 1'b0, 301, k);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule